// File: doc/BRIEF.md
# Two-Port Memory with Address-Collision Arbitration

This block is a synchronous memory with two fully independent access ports, called left and right. On every clock each port may read or write any word, and both ports may touch the same word in the same cycle. Every word is split into a lower and an upper byte lane. Each port selects the lanes it writes or reads with its own lane enables. A port whose chip enable is low does nothing.

When both enabled ports present the same address, an arbiter picks one winner. The other port is marked busy, and its write is blocked while its read still completes. The block has a role input. In the master role it decides collisions itself and drives the busy outputs. In the slave role its busy outputs stay low, and the busy inputs (driven by a master device's busy outputs) block writes on the matching port. This lets several devices be cascaded so that they behave as one wider memory.

Read data and busy outputs are registered and appear one cycle after the request. Write blocking takes effect on the same clock edge that would have stored the data.

Top module: `dpram_arb`

## Requirements
- R1: A read (chip enable high, write enable low) returns the addressed word one cycle later. The lower lane is bits [LANE_W-1:0] and the upper lane is bits [DATA_W-1:LANE_W], where LANE_W = DATA_W/2. A lane whose enable is low reads as zero.
- R2: A write (chip enable high, write enable high) stores only the lanes whose enables are high. The other lane of the stored word is unchanged.
- R3: With chip enable low, a port neither writes nor reads, and its read data output holds its previous value.
- R4: The two ports operate independently and in the same cycle when their addresses differ.
- R5: A busy output rises only in the cycle after both ports were enabled on equal addresses. At most one busy output is high at a time. Both busy outputs are low in the cycle after the addresses stop matching.
- R6: A new match is won by the port that already held that address in the previous cycle with its chip enable high. If neither or both ports held it, the left port wins. The winner stays the same for as long as the match continues.
- R7: In the master role (is_master = 1), the losing port's write is suppressed in the match cycle. A read by the losing port still returns the stored data.
- R8: In the slave role (is_master = 0), both busy outputs stay low and internal arbitration has no effect. A high busy input suppresses that port's writes, and that port's reads are unaffected.
- R9: When both ports write the same lane of the same word in one cycle and neither write is blocked, the left port's data is stored.
- R10: During synchronous reset (rst = 1), both read data outputs and both busy outputs are driven to zero.
- R11: A read returns the word as it was before any write in the same cycle, including a write by the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1: arbitrate and drive busy outputs; 0: obey busy inputs |
| l_ce | input | 1 | Left chip enable |
| l_we | input | 1 | Left write enable |
| l_ub | input | 1 | Left upper lane enable |
| l_lb | input | 1 | Left lower lane enable |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, registered |
| l_busy_i | input | 1 | Left busy from a master device (slave role) |
| l_busy_o | output | 1 | Left lost arbitration (master role), registered |
| r_ce | input | 1 | Right chip enable |
| r_we | input | 1 | Right write enable |
| r_ub | input | 1 | Right upper lane enable |
| r_lb | input | 1 | Right lower lane enable |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, registered |
| r_busy_i | input | 1 | Right busy from a master device (slave role) |
| r_busy_o | output | 1 | Right lost arbitration (master role), registered |

## Verification
Read data and busy flags are due exactly one clock after the edge that captures the request. A suppressed or allowed write shows up only through a later read, which is itself one cycle behind.

The bench drives inputs at the falling edge and advances its reference model once per rising edge. It then compares all four outputs at the next falling edge, so each comparison sees the result of the request made one cycle before.

Collision scenarios are built to place the first match cycle, the persisting match and the release on known edges. A random phase over a few addresses then exercises both roles.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  typedef enum logic {
    WIN_LEFT  = 1'b0,
    WIN_RIGHT = 1'b1
  } winner_e;

  localparam int unsigned N_LANES = 2;
endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_master,
  input  logic              l_ce,
  input  logic              r_ce,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_i,
  input  logic              r_busy_i,
  output logic              l_block,
  output logic              r_block,
  output logic              l_busy_o,
  output logic              r_busy_o
);
  logic              hit;
  logic              l_held, r_held;
  logic              hit_q;
  winner_e           win_q, win_now;
  logic              lp_ce, rp_ce;
  logic [ADDR_W-1:0] lp_addr, rp_addr;

  assign hit    = l_ce && r_ce && (l_addr == r_addr);
  assign l_held = lp_ce && (lp_addr == l_addr);
  assign r_held = rp_ce && (rp_addr == r_addr);

  always_comb begin
    if (hit_q)                 win_now = win_q;
    else if (r_held && !l_held) win_now = WIN_RIGHT;
    else                       win_now = WIN_LEFT;
  end

  always_comb begin
    if (is_master) begin
      l_block = hit && (win_now == WIN_RIGHT);
      r_block = hit && (win_now == WIN_LEFT);
    end else begin
      l_block = l_busy_i;
      r_block = r_busy_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q    <= 1'b0;
      win_q    <= WIN_LEFT;
      lp_ce    <= 1'b0;
      rp_ce    <= 1'b0;
      lp_addr  <= '0;
      rp_addr  <= '0;
      l_busy_o <= 1'b0;
      r_busy_o <= 1'b0;
    end else begin
      hit_q    <= hit;
      if (hit) win_q <= win_now;
      lp_ce    <= l_ce;
      rp_ce    <= r_ce;
      lp_addr  <= l_addr;
      rp_addr  <= r_addr;
      l_busy_o <= is_master && hit && (win_now == WIN_RIGHT);
      r_busy_o <= is_master && hit && (win_now == WIN_LEFT);
    end
  end
endmodule

// File: rtl/dpram_port_gate.sv
module dpram_port_gate
  import dpram_pkg::*;
(
  input  logic               ce,
  input  logic               we,
  input  logic               ub,
  input  logic               lb,
  input  logic               block,
  output logic [N_LANES-1:0] wlane,
  output logic               rd,
  output logic [N_LANES-1:0] rmask
);
  logic wr_ok;

  assign wr_ok = ce && we && !block;
  assign wlane = {N_LANES{wr_ok}} & {ub, lb};
  assign rd    = ce && !we;
  assign rmask = {ub, lb};
endmodule

// File: rtl/dpram_core.sv
module dpram_core
  import dpram_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  a_addr,
  input  logic [DATA_W-1:0]  a_wdata,
  input  logic [N_LANES-1:0] a_wlane,
  input  logic               a_rd,
  input  logic [N_LANES-1:0] a_rmask,
  output logic [DATA_W-1:0]  a_rdata,
  input  logic [ADDR_W-1:0]  b_addr,
  input  logic [DATA_W-1:0]  b_wdata,
  input  logic [N_LANES-1:0] b_wlane,
  input  logic               b_rd,
  input  logic [N_LANES-1:0] b_rmask,
  output logic [DATA_W-1:0]  b_rdata
);
  localparam int unsigned LANE_W = DATA_W / N_LANES;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    // Port a (left) is written last so it prevails on a shared lane.
    always_ff @(posedge clk) begin
      if (b_wlane[g]) mem[b_addr] <= b_wdata[g*LANE_W +: LANE_W];
      if (a_wlane[g]) mem[a_addr] <= a_wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        a_rdata[g*LANE_W +: LANE_W] <= '0;
        b_rdata[g*LANE_W +: LANE_W] <= '0;
      end else begin
        if (a_rd) a_rdata[g*LANE_W +: LANE_W] <= a_rmask[g] ? mem[a_addr] : '0;
        if (b_rd) b_rdata[g*LANE_W +: LANE_W] <= b_rmask[g] ? mem[b_addr] : '0;
      end
    end
  end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
  import dpram_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_master,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic              l_ub,
  input  logic              l_lb,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_busy_i,
  output logic              l_busy_o,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic              r_ub,
  input  logic              r_lb,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic              r_busy_i,
  output logic              r_busy_o
);
  logic               l_block, r_block;
  logic [N_LANES-1:0] l_wlane, r_wlane, l_rmask, r_rmask;
  logic               l_rd, r_rd;

  dpram_arbiter #(.ADDR_W(ADDR_W)) i_arbiter (
    .clk(clk), .rst(rst), .is_master(is_master),
    .l_ce(l_ce), .r_ce(r_ce), .l_addr(l_addr), .r_addr(r_addr),
    .l_busy_i(l_busy_i), .r_busy_i(r_busy_i),
    .l_block(l_block), .r_block(r_block),
    .l_busy_o(l_busy_o), .r_busy_o(r_busy_o)
  );

  dpram_port_gate i_gate_l (
    .ce(l_ce), .we(l_we), .ub(l_ub), .lb(l_lb), .block(l_block),
    .wlane(l_wlane), .rd(l_rd), .rmask(l_rmask)
  );

  dpram_port_gate i_gate_r (
    .ce(r_ce), .we(r_we), .ub(r_ub), .lb(r_lb), .block(r_block),
    .wlane(r_wlane), .rd(r_rd), .rmask(r_rmask)
  );

  dpram_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_core (
    .clk(clk), .rst(rst),
    .a_addr(l_addr), .a_wdata(l_wdata), .a_wlane(l_wlane),
    .a_rd(l_rd), .a_rmask(l_rmask), .a_rdata(l_rdata),
    .b_addr(r_addr), .b_wdata(r_wdata), .b_wlane(r_wlane),
    .b_rd(r_rd), .b_rmask(r_rmask), .b_rdata(r_rdata)
  );
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              is_master,
  input logic              l_ce,
  input logic              r_ce,
  input logic [ADDR_W-1:0] l_addr,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic [DATA_W-1:0] r_rdata,
  input logic              l_busy_o,
  input logic              r_busy_o
);
  logic same;
  assign same = l_ce && r_ce && (l_addr == r_addr);

  p_busy_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({l_busy_o, r_busy_o}));

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    !same |=> (!l_busy_o && !r_busy_o));

  p_one_loser_r6: assert property (@(posedge clk) disable iff (rst)
    (is_master && same) |=> ($countones({l_busy_o, r_busy_o}) == 1));

  p_keep_winner_r6: assert property (@(posedge clk) disable iff (rst)
    (is_master && same && l_busy_o) |=> l_busy_o);

  p_slave_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !is_master |=> (!l_busy_o && !r_busy_o));

  p_left_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !l_ce |=> $stable(l_rdata));

  p_right_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !r_ce |=> $stable(r_rdata));
endmodule

bind dpram_arb dpram_arb_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dpram_arb_chk (
  .clk(clk), .rst(rst), .is_master(is_master),
  .l_ce(l_ce), .r_ce(r_ce), .l_addr(l_addr), .r_addr(r_addr),
  .l_rdata(l_rdata), .r_rdata(r_rdata),
  .l_busy_o(l_busy_o), .r_busy_o(r_busy_o)
);

// File: tb/test_dpram_arb.sv
module test_dpram_arb;
  localparam int DW = 18;
  localparam int AW = 6;
  localparam int LW = DW / 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic is_master = 1'b1;
  logic l_ce = 0, l_we = 0, l_ub = 0, l_lb = 0, l_busy_i = 0;
  logic r_ce = 0, r_we = 0, r_ub = 0, r_lb = 0, r_busy_i = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_o, r_busy_o;

  always #10 clk = ~clk;

  dpram_arb #(.DATA_W(DW), .ADDR_W(AW)) i_dpram_arb (
    .clk(clk), .rst(rst), .is_master(is_master),
    .l_ce(l_ce), .l_we(l_we), .l_ub(l_ub), .l_lb(l_lb), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_busy_i(l_busy_i), .l_busy_o(l_busy_o),
    .r_ce(r_ce), .r_we(r_we), .r_ub(r_ub), .r_lb(r_lb), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_busy_i(r_busy_i), .r_busy_o(r_busy_o)
  );

  int tests = 0;
  int fails = 0;

  // behavioural reference state
  logic [DW-1:0] mm [DEPTH];
  logic [DW-1:0] e_lr = '0, e_rr = '0;
  logic e_lb = 0, e_rb = 0;
  logic m_hit_q = 0, m_win_r = 0, m_lpce = 0, m_rpce = 0;
  logic [AW-1:0] m_lpa = '0, m_rpa = '0;

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rd_lanes(input logic [DW-1:0] w, input logic ub, input logic lb);
    logic [DW-1:0] v;
    v = '0;
    if (lb) v[LW-1:0] = w[LW-1:0];
    if (ub) v[DW-1:LW] = w[DW-1:LW];
    return v;
  endfunction

  task automatic mdl_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic ub, input logic lb);
    if (lb) mm[a][LW-1:0] = d[LW-1:0];
    if (ub) mm[a][DW-1:LW] = d[DW-1:LW];
  endtask

  // one clock: model advances on current inputs, outputs compared at the next falling edge
  task automatic cyc(input string tag);
    logic hit, lh, rh, win_r, lblk, rblk;
    hit = l_ce && r_ce && (l_addr == r_addr);
    lh  = m_lpce && (m_lpa == l_addr);
    rh  = m_rpce && (m_rpa == r_addr);
    win_r = m_win_r;
    if (hit) win_r = m_hit_q ? m_win_r : (rh && !lh);
    lblk = is_master ? (hit && win_r)  : l_busy_i;
    rblk = is_master ? (hit && !win_r) : r_busy_i;
    e_lb = is_master && hit && win_r;
    e_rb = is_master && hit && !win_r;
    if (l_ce && !l_we) e_lr = rd_lanes(mm[l_addr], l_ub, l_lb);
    if (r_ce && !r_we) e_rr = rd_lanes(mm[r_addr], r_ub, r_lb);
    if (r_ce && r_we && !rblk) mdl_write(r_addr, r_wdata, r_ub, r_lb);
    if (l_ce && l_we && !lblk) mdl_write(l_addr, l_wdata, l_ub, l_lb);
    m_hit_q = hit;
    m_win_r = win_r;
    m_lpce = l_ce; m_rpce = r_ce; m_lpa = l_addr; m_rpa = r_addr;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "l_rdata", l_rdata, e_lr);
    chk(tag, "r_rdata", r_rdata, e_rr);
    chk(tag, "l_busy_o", {{(DW-1){1'b0}}, l_busy_o}, {{(DW-1){1'b0}}, e_lb});
    chk(tag, "r_busy_o", {{(DW-1){1'b0}}, r_busy_o}, {{(DW-1){1'b0}}, e_rb});
  endtask

  task automatic lset(input logic ce, input logic we, input logic ub, input logic lb,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_ce = ce; l_we = we; l_ub = ub; l_lb = lb; l_addr = a; l_wdata = d;
  endtask

  task automatic rset(input logic ce, input logic we, input logic ub, input logic lb,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_ce = ce; r_we = we; r_ub = ub; r_lb = lb; r_addr = a; r_wdata = d;
  endtask

  task automatic idle();
    lset(0, 0, 0, 0, '0, '0);
    rset(0, 0, 0, 0, '0, '0);
    l_busy_i = 0; r_busy_i = 0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #3_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R10: reset state
    idle();
    rst = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R10", "l_rdata", l_rdata, '0);
    chk("R10", "r_rdata", r_rdata, '0);
    chk("R10", "busy", {16'b0, l_busy_o, r_busy_o}, '0);
    rst = 0;

    // R4: fill memory, both ports writing distinct addresses at once
    for (int i = 0; i < DEPTH / 2; i++) begin
      lset(1, 1, 1, 1, AW'(i), DW'(i * 1111 + 7));
      rset(1, 1, 1, 1, AW'(i + DEPTH / 2), DW'(i * 2333 + 5));
      cyc("R4");
    end

    // R1: full and lane-selective reads
    lset(1, 0, 1, 1, 6'd3, '0); rset(1, 0, 1, 0, 6'd40, '0); cyc("R1");
    lset(1, 0, 0, 1, 6'd5, '0); rset(1, 0, 0, 0, 6'd41, '0); cyc("R1");

    // R2: upper only, then lower only, then read back
    lset(1, 1, 1, 0, 6'd7, 18'h3ffff); rset(1, 1, 0, 1, 6'd8, 18'h15555); cyc("R2");
    lset(1, 0, 1, 1, 6'd7, '0); rset(1, 0, 1, 1, 6'd8, '0); cyc("R2");

    // R3: deselected write is dropped and read data holds
    lset(0, 1, 1, 1, 6'd7, 18'h0); rset(0, 0, 1, 1, 6'd9, '0); cyc("R3");
    lset(1, 0, 1, 1, 6'd7, '0); rset(0, 0, 0, 0, '0, '0); cyc("R3");

    // R6/R7: simultaneous fresh match, left wins, right write blocked
    is_master = 1;
    idle(); cyc("R6");
    lset(1, 1, 1, 1, 6'd12, 18'h0aaaa); rset(1, 1, 1, 1, 6'd12, 18'h1bbbb); cyc("R6");
    lset(1, 0, 1, 1, 6'd12, '0); rset(1, 0, 1, 1, 6'd12, '0); cyc("R7");
    idle(); cyc("R5");

    // R6: right held the address first, so left loses; winner kept; release
    rset(1, 0, 1, 1, 6'd20, '0); cyc("R6");
    lset(1, 1, 1, 1, 6'd20, 18'h12345); cyc("R6");
    lset(1, 1, 1, 1, 6'd20, 18'h2abcd); cyc("R7");
    rset(1, 1, 1, 1, 6'd20, 18'h00f0f); cyc("R6");
    rset(1, 0, 1, 1, 6'd21, '0); lset(1, 0, 1, 1, 6'd20, '0); cyc("R5");
    cyc("R5");

    // R11: read sees the word before the other port's same-cycle write
    lset(1, 0, 1, 1, 6'd30, '0); rset(1, 1, 1, 1, 6'd31, 18'h0c0c0); cyc("R11");
    lset(1, 0, 1, 1, 6'd31, '0); rset(1, 1, 1, 1, 6'd30, 18'h3c3c3); cyc("R11");
    lset(1, 0, 1, 1, 6'd30, '0); rset(0, 0, 0, 0, '0, '0); cyc("R11");

    // R8/R9: slave role
    is_master = 0;
    lset(1, 1, 1, 1, 6'd14, 18'h11111); rset(1, 1, 1, 0, 6'd14, 18'h22222); cyc("R9");
    lset(1, 0, 1, 1, 6'd14, '0); rset(0, 0, 0, 0, '0, '0); cyc("R9");
    r_busy_i = 1;
    rset(1, 1, 1, 1, 6'd15, 18'h33333); lset(0, 0, 0, 0, '0, '0); cyc("R8");
    rset(1, 0, 1, 1, 6'd15, '0); cyc("R8");
    idle();

    // mixed random traffic on a few addresses, both roles
    for (int k = 0; k < 600; k++) begin
      if (k % 50 == 0) is_master = $urandom_range(0, 1);
      lset($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           AW'($urandom_range(0, 3)), DW'($urandom));
      rset($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           AW'($urandom_range(0, 3)), DW'($urandom));
      l_busy_i = $urandom_range(0, 1);
      r_busy_i = $urandom_range(0, 1);
      cyc("R6");
    end

    summary();
    $finish;
  end
endmodule